// File: doc/BRIEF.md
# Load/store memory port

This block is a single-requester load/store port that sits between a processor's memory request interface and a local byte-addressable memory. The local memory is 256 words of 64 bits, so it holds 2048 bytes. A requester issues one access at a time. Each request carries:

- a byte address with a valid flag,
- a length code selecting 1, 2, 4 or 8 bytes,
- a privilege bit,
- for stores, a flag asking for a whole aligned line to be cleared.

The port checks each request in the cycle it is presented. A bad request is refused through an exception record, with no acknowledge and no memory update. A good request is acknowledged. A store then takes one cycle of data under a strobe. A load returns zero-extended data under a valid flag. A requester ends an access by dropping its select inputs.

The handshake is split into four signals: busy, address-acknowledge, a one-cycle store strobe and load-valid. After a store has written, busy falls while the requester still holds its selects. The port does not take a new request until the selects have been low for a cycle.

Top module: `lsp_port`

## Requirements
- R1: After reset, busy_o, addr_ack_o, ld_vld_o and every exception output are low.
- R2: A request is taken on the first clock edge where busy_o is low, ld_sel_i or st_sel_i is high, and addr_vld_i is high.
  - For a valid request, addr_ack_o and busy_o are high from the following cycle.
  - For a load, ld_vld_o rises exactly one cycle after addr_ack_o, with the data on ld_data_o.
  - For a store, the write happens on the edge where st_vld_i is high. busy_o is low from the next cycle while addr_ack_o stays high, until the selects drop.
- R3: The length code len_i is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Load data is zero-extended, and store data bits above the length are ignored.
- R4: Memory is little-endian. Byte k of an access lives at byte address addr+k, which is lane (addr mod 8)+k of word addr/8. A store changes only the lanes it covers, so two halfword stores at A and A+2 read back from a word load at A as first | (second << 16).
- R5: An access whose address is not a multiple of its length raises exc_happened_o with exc_misalign_o. It gets no acknowledge and leaves memory unchanged, and a store strobe during the fault is ignored. Line-clearing stores are never misaligned.
- R6: An access at a byte address of 2048 or more raises exc_happened_o with exc_range_o and leaves memory unchanged.
- R7: An access with priv_i high (unprivileged) to a byte address below 256 raises exc_happened_o with exc_perm_o and leaves memory unchanged. Causes that apply together are all reported.
- R8: A store with zero_line_i high still takes its strobe. It then ignores the store data and the length, and writes zeros over the 32-byte block whose address is addr rounded down to 32. This takes one word per cycle, and busy_o stays high for exactly 4 cycles after the strobe edge. Neighbouring blocks are unchanged.
- R9: When both selects are low outside the idle and clearing states, the port is idle from the next cycle, with busy_o, addr_ack_o, ld_vld_o and exc_happened_o low. A store abandoned before its strobe leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_sel_i | input | 1 | Load select (wins if both selects are high) |
| st_sel_i | input | 1 | Store select |
| zero_line_i | input | 1 | Store clears the aligned 32-byte line |
| len_i | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 bytes |
| priv_i | input | 1 | 1 = unprivileged access |
| addr_i | input | 16 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, right-aligned |
| st_vld_i | input | 1 | One-cycle store data strobe |
| busy_o | output | 1 | Port busy; no new request may start |
| addr_ack_o | output | 1 | Address taken |
| ld_data_o | output | 64 | Load data, zero-extended |
| ld_vld_o | output | 1 | Load data valid |
| exc_happened_o | output | 1 | Exception raised for the current request |
| exc_misalign_o | output | 1 | Cause: misaligned |
| exc_range_o | output | 1 | Cause: outside memory |
| exc_perm_o | output | 1 | Cause: unprivileged access to protected range |

## Verification
The assertions take for granted that the requester follows the handshake:

- it raises a request only while busy_o is low,
- it holds select, address and length steady until it sees an acknowledge or an exception,
- it pulses st_vld_i for a single cycle and only after the acknowledge,
- it drops both selects to finish.

The bench drives every request through two tasks that wait on busy_o, addr_ack_o and exc_happened_o before changing anything. Inputs change only on falling edges. The only deliberate departures are to drop the selects early, to pulse a strobe into a faulted store, and to hold the selects after a completed store. All three are behaviour the port defines.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  localparam int LSP_DW    = 64;
  localparam int LSP_LANES = LSP_DW / 8;
  localparam int LSP_OFF_W = $clog2(LSP_LANES);

  typedef enum logic [1:0] {
    LEN_B = 2'd0,
    LEN_H = 2'd1,
    LEN_W = 2'd2,
    LEN_D = 2'd3
  } len_e;

  typedef struct packed {
    logic happened;
    logic perm;
    logic range;
    logic misalign;
  } exc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_LDV,
    ST_ZERO,
    ST_DONE,
    ST_FAULT
  } state_e;

  function automatic logic [LSP_LANES-1:0] len_mask(len_e l);
    case (l)
      LEN_B:   len_mask = LSP_LANES'(8'h01);
      LEN_H:   len_mask = LSP_LANES'(8'h03);
      LEN_W:   len_mask = LSP_LANES'(8'h0f);
      default: len_mask = LSP_LANES'(8'hff);
    endcase
  endfunction

endpackage

// File: rtl/lsp_check.sv
module lsp_check
  import lsp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MEM_BYTES  = 2048,
  parameter int PROT_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  len_e              len_i,
  input  logic              priv_i,
  input  logic              zero_i,
  output exc_t              exc_o
);

  logic [ADDR_W:0] addr_x;
  logic            mis;

  assign addr_x = {1'b0, addr_i};

  always_comb begin
    case (len_i)
      LEN_B:   mis = 1'b0;
      LEN_H:   mis = addr_i[0];
      LEN_W:   mis = |addr_i[1:0];
      default: mis = |addr_i[2:0];
    endcase
  end

  always_comb begin
    exc_o.misalign = mis & ~zero_i;
    exc_o.range    = addr_x >= (ADDR_W+1)'(MEM_BYTES);
    exc_o.perm     = priv_i & (addr_x < (ADDR_W+1)'(PROT_BYTES));
    exc_o.happened = exc_o.misalign | exc_o.range | exc_o.perm;
  end

endmodule

// File: rtl/lsp_lanes.sv
module lsp_lanes
  import lsp_pkg::*;
(
  input  logic [LSP_DW-1:0]    st_data_i,
  input  logic [LSP_OFF_W-1:0] off_i,
  input  len_e                 len_i,
  input  logic                 zero_i,
  output logic [LSP_DW-1:0]    wdata_o,
  output logic [LSP_LANES-1:0] wbe_o,
  input  logic [LSP_DW-1:0]    rdata_i,
  output logic [LSP_DW-1:0]    ld_data_o
);

  logic [LSP_LANES-1:0] mask;
  logic [LSP_DW-1:0]    shifted;
  logic [LSP_DW-1:0]    bitmask;

  assign mask    = len_mask(len_i);
  assign shifted = rdata_i >> {off_i, 3'b000};

  for (genvar l = 0; l < LSP_LANES; l++) begin : g_mask
    assign bitmask[8*l +: 8] = {8{mask[l]}};
  end

  assign ld_data_o = shifted & bitmask;

  always_comb begin
    if (zero_i) begin
      wdata_o = '0;
      wbe_o   = '1;
    end else begin
      wdata_o = (st_data_i & bitmask) << {off_i, 3'b000};
      wbe_o   = mask << off_i;
    end
  end

endmodule

// File: rtl/lsp_mem.sv
module lsp_mem #(
  parameter int DEPTH = 256,
  parameter int LANES = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               we_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [8*LANES-1:0] wdata_i,
  input  logic               re_i,
  output logic [8*LANES-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] arr [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) arr[addr_i] <= wdata_i[8*l +: 8];
      if (re_i) rd_q <= arr[addr_i];
    end

    assign rdata_o[8*l +: 8] = rd_q;
  end

endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
  import lsp_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int CNT_W     = $clog2(LINE_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_sel_i,
  input  logic             st_sel_i,
  input  logic             addr_vld_i,
  input  logic             st_vld_i,
  input  logic             zero_i,
  input  exc_t             exc_i,
  output logic             cap_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic             zeroing_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             addr_ack_o,
  output logic             ld_vld_o,
  output exc_t             exc_o
);

  state_e           state_q, state_d;
  logic             ld_q, zero_q;
  logic [CNT_W-1:0] cnt_q;
  exc_t             exc_q;
  logic             sel, req;

  assign sel = ld_sel_i | st_sel_i;
  assign req = sel & addr_vld_i;

  always_comb begin
    state_d  = state_q;
    cap_o    = 1'b0;
    mem_we_o = 1'b0;
    mem_re_o = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin
        cap_o   = 1'b1;
        state_d = exc_i.happened ? ST_FAULT : ST_ACK;
      end
      ST_ACK: begin
        if (!sel) begin
          state_d = ST_IDLE;
        end else if (ld_q) begin
          mem_re_o = 1'b1;
          state_d  = ST_LDV;
        end else if (st_vld_i) begin
          if (zero_q) begin
            state_d = ST_ZERO;
          end else begin
            mem_we_o = 1'b1;
            state_d  = ST_DONE;
          end
        end
      end
      ST_ZERO: begin
        mem_we_o = 1'b1;
        if (cnt_q == CNT_W'(LINE_WORDS - 1)) state_d = ST_DONE;
      end
      ST_LDV, ST_DONE, ST_FAULT: if (!sel) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ld_q    <= 1'b0;
      zero_q  <= 1'b0;
      cnt_q   <= '0;
      exc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cap_o) begin
        ld_q   <= ld_sel_i;
        zero_q <= zero_i & ~ld_sel_i;
        exc_q  <= exc_i;
      end
      if (state_q == ST_ZERO) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
    end
  end

  assign zeroing_o  = state_q == ST_ZERO;
  assign cnt_o      = cnt_q;
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign addr_ack_o = (state_q == ST_ACK) || (state_q == ST_LDV) ||
                      (state_q == ST_ZERO) || (state_q == ST_DONE);
  assign ld_vld_o   = state_q == ST_LDV;
  assign exc_o      = (state_q == ST_FAULT) ? exc_q : '0;

  p_ack_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_ack_o && exc_o.happened));

  p_ldvld_after_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_vld_o) |-> $past(addr_ack_o) && !$past(ld_vld_o));

  p_drop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && (addr_ack_o || exc_o.happened) && !zeroing_o) |=>
      (!busy_o && !addr_ack_o && !ld_vld_o && !exc_o.happened));

  p_zero_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zeroing_o) |-> ##3 (zeroing_o && busy_o));

endmodule

// File: rtl/lsp_port.sv
module lsp_port
  import lsp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DEPTH      = 256,
  parameter int LINE_BYTES = 32,
  parameter int PROT_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_sel_i,
  input  logic              st_sel_i,
  input  logic              zero_line_i,
  input  logic [1:0]        len_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [63:0]       st_data_i,
  input  logic              st_vld_i,
  output logic              busy_o,
  output logic              addr_ack_o,
  output logic [63:0]       ld_data_o,
  output logic              ld_vld_o,
  output logic              exc_happened_o,
  output logic              exc_misalign_o,
  output logic              exc_range_o,
  output logic              exc_perm_o
);

  localparam int MEM_BYTES  = DEPTH * LSP_LANES;
  localparam int WADDR_W    = $clog2(DEPTH);
  localparam int QA_W       = LSP_OFF_W + WADDR_W;
  localparam int LINE_WORDS = LINE_BYTES / LSP_LANES;
  localparam int CNT_W      = $clog2(LINE_WORDS);

  logic                 zero_st;
  exc_t                 chk_exc, exc;
  logic                 cap, mem_we, mem_re, zeroing;
  logic [CNT_W-1:0]     cnt;
  logic [QA_W-1:0]      addr_q;
  len_e                 len_q;
  logic [WADDR_W-1:0]   widx, mem_addr;
  logic [LSP_DW-1:0]    mem_wdata, mem_rdata;
  logic [LSP_LANES-1:0] mem_be;

  assign zero_st = zero_line_i & st_sel_i & ~ld_sel_i;

  lsp_check #(
    .ADDR_W    (ADDR_W),
    .MEM_BYTES (MEM_BYTES),
    .PROT_BYTES(PROT_BYTES)
  ) u_check (
    .addr_i(addr_i),
    .len_i (len_e'(len_i)),
    .priv_i(priv_i),
    .zero_i(zero_st),
    .exc_o (chk_exc)
  );

  lsp_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_sel_i  (ld_sel_i),
    .st_sel_i  (st_sel_i),
    .addr_vld_i(addr_vld_i),
    .st_vld_i  (st_vld_i),
    .zero_i    (zero_line_i),
    .exc_i     (chk_exc),
    .cap_o     (cap),
    .mem_we_o  (mem_we),
    .mem_re_o  (mem_re),
    .zeroing_o (zeroing),
    .cnt_o     (cnt),
    .busy_o    (busy_o),
    .addr_ack_o(addr_ack_o),
    .ld_vld_o  (ld_vld_o),
    .exc_o     (exc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= LEN_B;
    end else if (cap) begin
      addr_q <= addr_i[QA_W-1:0];
      len_q  <= len_e'(len_i);
    end
  end

  assign widx     = addr_q[QA_W-1:LSP_OFF_W];
  assign mem_addr = zeroing ? {widx[WADDR_W-1:CNT_W], cnt} : widx;

  lsp_lanes u_lanes (
    .st_data_i(st_data_i),
    .off_i    (addr_q[LSP_OFF_W-1:0]),
    .len_i    (len_q),
    .zero_i   (zeroing),
    .wdata_o  (mem_wdata),
    .wbe_o    (mem_be),
    .rdata_i  (mem_rdata),
    .ld_data_o(ld_data_o)
  );

  lsp_mem #(.DEPTH(DEPTH), .LANES(LSP_LANES)) u_mem (
    .clk_i  (clk_i),
    .addr_i (mem_addr),
    .we_i   (mem_we),
    .be_i   (mem_be),
    .wdata_i(mem_wdata),
    .re_i   (mem_re),
    .rdata_o(mem_rdata)
  );

  assign exc_happened_o = exc.happened;
  assign exc_misalign_o = exc.misalign;
  assign exc_range_o    = exc.range;
  assign exc_perm_o     = exc.perm;

  p_no_write_on_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_happened_o |-> !mem_we);

  p_be_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (mem_be != '0));

  p_zero_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && zeroing) |-> (mem_wdata == '0) && (mem_be == '1));

endmodule

// File: tb/sim_lsp_port.sv
module sim_lsp_port;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_sel = 1'b0, st_sel = 1'b0, zero_line = 1'b0, priv = 1'b0;
  logic [1:0]  len = 2'd0;
  logic [15:0] addr = '0;
  logic        addr_vld = 1'b0;
  logic [63:0] st_data = '0;
  logic        st_vld = 1'b0;
  logic        busy, addr_ack, ld_vld, exc_h, exc_mis, exc_rng, exc_prm;
  logic [63:0] ld_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsp_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ld_sel_i(ld_sel), .st_sel_i(st_sel),
    .zero_line_i(zero_line), .len_i(len), .priv_i(priv), .addr_i(addr),
    .addr_vld_i(addr_vld), .st_data_i(st_data), .st_vld_i(st_vld),
    .busy_o(busy), .addr_ack_o(addr_ack), .ld_data_o(ld_data), .ld_vld_o(ld_vld),
    .exc_happened_o(exc_h), .exc_misalign_o(exc_mis), .exc_range_o(exc_rng),
    .exc_perm_o(exc_prm)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      $display("FAIL watchdog: run hung act=%0d exp<%0d", cycles, WATCHDOG);
      errors = errors + 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drop();
    ld_sel = 0; st_sel = 0; addr_vld = 0; zero_line = 0; st_vld = 0;
  endtask

  // exc code: {perm, range, misalign}
  task automatic do_store(input logic p, input logic [1:0] l, input logic [15:0] a,
                          input logic [63:0] d, input logic z,
                          output logic [2:0] e, output int bcnt);
    e = 3'b000; bcnt = 0;
    while (busy) @(negedge clk);
    st_sel = 1; priv = p; len = l; addr = a; addr_vld = 1; zero_line = z;
    @(negedge clk);
    while (!(addr_ack || exc_h)) @(negedge clk);
    if (exc_h) begin
      e = {exc_prm, exc_rng, exc_mis};
      st_data = d; st_vld = 1;          // strobe into a faulted store
      @(negedge clk);
      drop();
      @(negedge clk);
      return;
    end
    st_data = d; st_vld = 1;
    @(negedge clk);
    st_vld = 0;
    while (busy) begin bcnt++; @(negedge clk); end
    drop();
    @(negedge clk);
  endtask

  task automatic do_load(input logic p, input logic [1:0] l, input logic [15:0] a,
                         output logic [63:0] d, output logic [2:0] e);
    e = 3'b000; d = '0;
    while (busy) @(negedge clk);
    ld_sel = 1; priv = p; len = l; addr = a; addr_vld = 1;
    @(negedge clk);
    while (!(addr_ack || exc_h)) @(negedge clk);
    if (exc_h) begin
      e = {exc_prm, exc_rng, exc_mis};
      @(negedge clk);
      drop();
      @(negedge clk);
      return;
    end
    while (!ld_vld) @(negedge clk);
    d = ld_data;
    drop();
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        ld;
    logic        priv;
    logic [1:0]  len;
    logic [15:0] addr;
    logic [63:0] data;
    logic [2:0]  exc;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd3, 16'h0100, 64'h0,                   3'b000},
    '{1'b0, 1'b0, 2'd1, 16'h0100, 64'h1234,                3'b000},
    '{1'b0, 1'b0, 2'd1, 16'h0102, 64'habcd,                3'b000},
    '{1'b1, 1'b0, 2'd1, 16'h0100, 64'h1234,                3'b000},
    '{1'b1, 1'b0, 2'd1, 16'h0102, 64'habcd,                3'b000},
    '{1'b1, 1'b0, 2'd2, 16'h0100, 64'habcd1234,            3'b000},
    '{1'b0, 1'b0, 2'd0, 16'h0105, 64'h5a,                  3'b000},
    '{1'b1, 1'b0, 2'd3, 16'h0100, 64'h00005a00abcd1234,    3'b000},
    '{1'b0, 1'b0, 2'd3, 16'h0108, 64'h0123456789abcdef,    3'b000},
    '{1'b1, 1'b0, 2'd0, 16'h010b, 64'h89,                  3'b000},
    '{1'b1, 1'b0, 2'd1, 16'h010e, 64'h0123,                3'b000},
    '{1'b1, 1'b0, 2'd2, 16'h010c, 64'h01234567,            3'b000},
    '{1'b0, 1'b0, 2'd3, 16'h0110, 64'h0,                   3'b000},
    '{1'b0, 1'b0, 2'd0, 16'h0110, 64'hffffff77,            3'b000},
    '{1'b1, 1'b0, 2'd3, 16'h0110, 64'h77,                  3'b000},
    '{1'b1, 1'b0, 2'd1, 16'h0101, 64'h0,                   3'b001},
    '{1'b0, 1'b0, 2'd2, 16'h0112, 64'hdeadbeef,            3'b001},
    '{1'b1, 1'b0, 2'd3, 16'h0110, 64'h77,                  3'b000},
    '{1'b1, 1'b0, 2'd0, 16'h0800, 64'h0,                   3'b010},
    '{1'b0, 1'b0, 2'd3, 16'h07f8, 64'hcafef00d12345678,    3'b000},
    '{1'b1, 1'b0, 2'd3, 16'h07f8, 64'hcafef00d12345678,    3'b000},
    '{1'b1, 1'b1, 2'd0, 16'h00ff, 64'h0,                   3'b100},
    '{1'b1, 1'b1, 2'd3, 16'h0108, 64'h0123456789abcdef,    3'b000},
    '{1'b0, 1'b1, 2'd3, 16'h00f8, 64'h1,                   3'b100},
    '{1'b1, 1'b0, 2'd3, 16'hfff8, 64'h0,                   3'b010},
    '{1'b1, 1'b1, 2'd1, 16'h0001, 64'h0,                   3'b101}
  };

  initial begin
    logic [63:0] d;
    logic [2:0]  e;
    int          bc;

    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk("R1 busy", {63'b0, busy}, 64'd0);
    chk("R1 ack", {63'b0, addr_ack}, 64'd0);
    chk("R1 ldvld", {63'b0, ld_vld}, 64'd0);
    chk("R1 exc", {60'b0, exc_h, exc_prm, exc_rng, exc_mis}, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].ld) begin
        do_load(VEC[i].priv, VEC[i].len, VEC[i].addr, d, e);
        chk($sformatf("R5 R6 R7 exc vec %0d", i), {61'b0, e}, {61'b0, VEC[i].exc});
        if (VEC[i].exc == 3'b000)
          chk($sformatf("R3 R4 load data vec %0d", i), d, VEC[i].data);
      end else begin
        do_store(VEC[i].priv, VEC[i].len, VEC[i].addr, VEC[i].data, 1'b0, e, bc);
        chk($sformatf("R5 R6 R7 exc vec %0d", i), {61'b0, e}, {61'b0, VEC[i].exc});
      end
    end

    // R2 load timing
    ld_sel = 1; priv = 0; len = 2'd3; addr = 16'h0108; addr_vld = 1;
    @(negedge clk);
    chk("R2 ack after take", {62'b0, addr_ack, busy}, 64'd3);
    chk("R2 no ldvld yet", {63'b0, ld_vld}, 64'd0);
    @(negedge clk);
    chk("R2 ldvld next", {63'b0, ld_vld}, 64'd1);
    chk("R2 load data", ld_data, 64'h0123456789abcdef);
    drop();
    @(negedge clk);
    chk("R9 idle after drop", {61'b0, busy, addr_ack, ld_vld}, 64'd0);

    // R2 store: busy falls while selects held, no re-take
    st_sel = 1; len = 2'd3; addr = 16'h0118; addr_vld = 1;
    @(negedge clk);
    chk("R2 store ack", {63'b0, addr_ack}, 64'd1);
    st_data = 64'h2222; st_vld = 1;
    @(negedge clk);
    st_vld = 0;
    chk("R2 store done busy/ack", {62'b0, busy, addr_ack}, 64'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R2 held sel not retaken", {62'b0, busy, addr_ack}, 64'd1);
    drop();
    @(negedge clk);

    // R9 abandoned store leaves memory intact
    do_store(0, 2'd3, 16'h0140, 64'h1111, 1'b0, e, bc);
    st_sel = 1; len = 2'd3; addr = 16'h0140; addr_vld = 1; st_data = 64'h9999;
    @(negedge clk);
    chk("R9 abandon ack", {63'b0, addr_ack}, 64'd1);
    drop();
    @(negedge clk);
    chk("R9 abandon idle", {62'b0, busy, addr_ack}, 64'd0);
    do_load(0, 2'd3, 16'h0140, d, e);
    chk("R9 abandoned store no write", d, 64'h1111);

    // R5 fault handling and drop
    ld_sel = 1; len = 2'd1; addr = 16'h0101; addr_vld = 1;
    @(negedge clk);
    chk("R5 fault flags", {61'b0, exc_h, exc_mis, addr_ack}, 64'd6);
    @(negedge clk);
    drop();
    @(negedge clk);
    chk("R9 fault cleared", {62'b0, exc_h, busy}, 64'd0);

    // R8 line clear
    for (int k = 0; k < 4; k++)
      do_store(0, 2'd3, 16'h0120 + 16'(8*k), 64'hffff0000 + 64'(k), 1'b0, e, bc);
    do_store(0, 2'd0, 16'h012c, 64'hff, 1'b1, e, bc);
    chk("R8 clear exc", {61'b0, e}, 64'd0);
    chk("R8 busy cycles", 64'(bc), 64'd4);
    for (int k = 0; k < 4; k++) begin
      do_load(0, 2'd3, 16'h0120 + 16'(8*k), d, e);
      chk($sformatf("R8 word %0d zeroed", k), d, 64'd0);
    end
    do_load(0, 2'd3, 16'h0140, d, e);
    chk("R8 next line intact", d, 64'h1111);
    do_load(0, 2'd3, 16'h0118, d, e);
    chk("R8 prev line intact", d, 64'h2222);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule